// File: doc/BRIEF.md
# Machine Cycle and Retire Counters

This block holds two 64-bit counters for a processor core: one counts clock steps and the other counts retired instructions. Software reads and writes each counter as two 32-bit words, a low word and a high word. A single step pulse moves both counters forward. The retire counter also needs a retire strobe in the same cycle. A 3-bit inhibit register can stop either counter.

The increment is always computed on the full 64-bit value, so a carry from the low word reaches the high word. A software write lands on the same clock edge as the increment and replaces only the word it targets. The other word of that counter still takes its incremented value. A write to the inhibit register also lands after that edge's increment, so the increment on that edge still uses the old inhibit value.

Top module: `ctr_pair_top`

## Requirements
- R1: After reset, all four counter words and the inhibit register read zero.
- R2: On each clock edge with `step_i` high and inhibit bit 0 clear, the cycle counter advances by one. With `step_i` low it holds its value unless written.
- R3: The retire counter advances by one only on an edge where `step_i` and `retire_i` are both high and inhibit bit 2 is clear.
- R4: Inhibit bit 0 stops only the cycle counter and inhibit bit 2 stops only the retire counter. Bit 1 has no effect on either counter.
- R5: When the low word of a counter is 0xFFFFFFFF and the counter advances, the low word wraps to zero and the high word rises by one.
- R6: A write to one word of a counter replaces that word on the edge. On the same edge the other word takes its value from the incremented 64-bit count, including any carry.
- R7: A write to the inhibit register stores data bits 2 and 0 and clears every other bit, so bit 1 reads zero. The increment on the same edge uses the inhibit value held before the write.
- R8: Word select `wr_sel_i` codes: 0 = cycle low, 1 = cycle high, 2 = retire low, 3 = retire high.
- R9: Counter writes and inhibit writes take effect whether or not `step_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance pulse, one per step |
| retire_i | input | 1 | An instruction retires in this step |
| wr_en_i | input | 1 | Counter word write enable |
| wr_sel_i | input | 2 | Word select (see R8) |
| wr_data_i | input | 32 | Counter write data |
| inh_we_i | input | 1 | Inhibit register write enable |
| inh_data_i | input | 32 | Inhibit write data (bits 2 and 0 kept) |
| cyc_lo_o | output | 32 | Cycle counter, low word |
| cyc_hi_o | output | 32 | Cycle counter, high word |
| ret_lo_o | output | 32 | Retire counter, low word |
| ret_hi_o | output | 32 | Retire counter, high word |
| inh_o | output | 3 | Inhibit register value |

## Verification
Every result, whether an increment, a word write or an inhibit update, appears on the outputs exactly one rising edge after the inputs that cause it. The bench changes inputs only on the falling edge. It then compares the outputs on the next falling edge, half a period after the rising edge that produced them. An inhibit write is checked by its effect one edge later, where the increment must still follow the old value, and again on the edge after that, where the new value is in force. Carry cases are set up with writes issued while `step_i` is low, so that the wrap happens on one known edge.

// File: rtl/ctr_pair_pkg.sv
package ctr_pair_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned INH_W  = 3;
    localparam int unsigned CYC_INH_BIT = 0;
    localparam int unsigned RET_INH_BIT = 2;

    typedef enum logic [1:0] {
        SEL_CYC_LO = 2'd0,
        SEL_CYC_HI = 2'd1,
        SEL_RET_LO = 2'd2,
        SEL_RET_HI = 2'd3
    } word_sel_e;
endpackage

// File: rtl/split_counter.sv
module split_counter #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned HALVES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    input  logic                       wr_en_i,
    input  logic [$clog2(HALVES)-1:0]  wr_half_i,
    input  logic [WORD_W-1:0]          wr_data_i,
    output logic [HALVES*WORD_W-1:0]   value_o
);
    localparam int unsigned FULL_W = HALVES * WORD_W;
    localparam int unsigned SEL_W  = $clog2(HALVES);

    logic [WORD_W-1:0] half_q [HALVES];
    logic [FULL_W-1:0] sum;

    assign sum = value_o + {{(FULL_W-1){1'b0}}, adv_i};

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (wr_en_i && (wr_half_i == SEL_W'(h))) begin
                half_q[h] <= wr_data_i;
            end else begin
                half_q[h] <= sum[h*WORD_W +: WORD_W];
            end
        end
        assign value_o[h*WORD_W +: WORD_W] = half_q[h];
    end

    // R2 R5
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wr_en_i) |=> (value_o == $past(value_o) + FULL_W'(1)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !wr_en_i) |=> $stable(value_o));

    // R6
    wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_half_i == '0) |=> (value_o[WORD_W-1:0] == $past(wr_data_i)));

    // R6
    wr_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_half_i != '0 && adv_i)
        |=> (value_o[WORD_W-1:0] == $past(value_o[WORD_W-1:0]) + WORD_W'(1)));
endmodule

// File: rtl/inhibit_reg.sv
module inhibit_reg
    import ctr_pair_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [INH_W-1:0]  inh_o
);
    localparam logic [INH_W-1:0] KEEP_MASK =
        INH_W'((1 << CYC_INH_BIT) | (1 << RET_INH_BIT));

    logic [INH_W-1:0] inh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inh_q <= '0;
        end else if (we_i) begin
            inh_q <= data_i[INH_W-1:0] & KEEP_MASK;
        end
    end

    assign inh_o = inh_q;

    // R7
    inh_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (inh_o == {$past(data_i[2]), 1'b0, $past(data_i[0])}));

    // R7
    inh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(inh_o));
endmodule

// File: rtl/ctr_pair_top.sv
module ctr_pair_top
    import ctr_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              retire_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              inh_we_i,
    input  logic [WORD_W-1:0] inh_data_i,
    output logic [WORD_W-1:0] cyc_lo_o,
    output logic [WORD_W-1:0] cyc_hi_o,
    output logic [WORD_W-1:0] ret_lo_o,
    output logic [WORD_W-1:0] ret_hi_o,
    output logic [INH_W-1:0]  inh_o
);
    logic [INH_W-1:0]    inh;
    logic                cyc_adv, ret_adv;
    logic                cyc_we, ret_we;
    logic [2*WORD_W-1:0] cyc_val, ret_val;
    word_sel_e           sel;

    assign sel     = word_sel_e'(wr_sel_i);
    assign cyc_we  = wr_en_i && (sel == SEL_CYC_LO || sel == SEL_CYC_HI);
    assign ret_we  = wr_en_i && (sel == SEL_RET_LO || sel == SEL_RET_HI);
    assign cyc_adv = step_i && !inh[CYC_INH_BIT];
    assign ret_adv = step_i && retire_i && !inh[RET_INH_BIT];

    inhibit_reg #(.DATA_W(WORD_W)) u_inh (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (inh_we_i),
        .data_i (inh_data_i),
        .inh_o  (inh)
    );

    split_counter #(.WORD_W(WORD_W), .HALVES(2)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (cyc_adv),
        .wr_en_i   (cyc_we),
        .wr_half_i (wr_sel_i[0]),
        .wr_data_i (wr_data_i),
        .value_o   (cyc_val)
    );

    split_counter #(.WORD_W(WORD_W), .HALVES(2)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (ret_adv),
        .wr_en_i   (ret_we),
        .wr_half_i (wr_sel_i[0]),
        .wr_data_i (wr_data_i),
        .value_o   (ret_val)
    );

    assign cyc_lo_o = cyc_val[WORD_W-1:0];
    assign cyc_hi_o = cyc_val[2*WORD_W-1:WORD_W];
    assign ret_lo_o = ret_val[WORD_W-1:0];
    assign ret_hi_o = ret_val[2*WORD_W-1:WORD_W];
    assign inh_o    = inh;

    // R4
    cyc_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_o[CYC_INH_BIT] && !cyc_we) |=> ({cyc_hi_o, cyc_lo_o} == $past({cyc_hi_o, cyc_lo_o})));

    // R3
    ret_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !ret_we) |=> ({ret_hi_o, ret_lo_o} == $past({ret_hi_o, ret_lo_o})));

    // R4
    ret_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_o[RET_INH_BIT] && !ret_we) |=> $stable({ret_hi_o, ret_lo_o}));
endmodule

// File: tb/test_ctr_pair_top.sv
`timescale 1ns/1ps
module test_ctr_pair_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, retire_i = 1'b0, wr_en_i = 1'b0, inh_we_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [31:0] wr_data_i = '0, inh_data_i = '0;
    logic [31:0] cyc_lo_o, cyc_hi_o, ret_lo_o, ret_hi_o;
    logic [2:0]  inh_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctr_pair_top i_ctr_pair_top (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .retire_i(retire_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .inh_we_i(inh_we_i), .inh_data_i(inh_data_i),
        .cyc_lo_o(cyc_lo_o), .cyc_hi_o(cyc_hi_o), .ret_lo_o(ret_lo_o),
        .ret_hi_o(ret_hi_o), .inh_o(inh_o)
    );

    typedef struct packed {
        logic        step;
        logic        ret;
        logic        we;
        logic [1:0]  sel;
        logic [31:0] wd;
        logic        iwe;
        logic [31:0] id;
        logic [31:0] e_cl;
        logic [31:0] e_ch;
        logic [31:0] e_rl;
        logic [31:0] e_rh;
        logic [2:0]  e_inh;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 32'd0,   1'b0, 32'd0,          32'd1,   32'd0, 32'd0, 32'd0, 3'd0}, // R2
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b0, 32'd0,          32'd2,   32'd0, 32'd1, 32'd0, 3'd0}, // R3
        '{1'b0, 1'b1, 1'b0, 2'd0, 32'd0,   1'b0, 32'd0,          32'd2,   32'd0, 32'd1, 32'd0, 3'd0}, // R2 R3 no step
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b1, 32'h1,          32'd3,   32'd0, 32'd2, 32'd0, 3'd1}, // R7 old inhibit
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b0, 32'd0,          32'd3,   32'd0, 32'd3, 32'd0, 3'd1}, // R4 bit0
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b1, 32'hFFFF_FFFF,  32'd3,   32'd0, 32'd4, 32'd0, 3'd5}, // R7 mask
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b0, 32'd0,          32'd3,   32'd0, 32'd4, 32'd0, 3'd5}, // R4 bit2
        '{1'b1, 1'b1, 1'b0, 2'd0, 32'd0,   1'b1, 32'h2,          32'd3,   32'd0, 32'd4, 32'd0, 3'd0}, // R4 R7 bit1
        '{1'b1, 1'b0, 1'b1, 2'd0, 32'd100, 1'b0, 32'd0,          32'd100, 32'd0, 32'd4, 32'd0, 3'd0}, // R6 R8 sel0
        '{1'b1, 1'b1, 1'b1, 2'd2, 32'd7,   1'b0, 32'd0,          32'd101, 32'd0, 32'd7, 32'd0, 3'd0}, // R6 R8 sel2
        '{1'b0, 1'b0, 1'b1, 2'd1, 32'd5,   1'b0, 32'd0,          32'd101, 32'd5, 32'd7, 32'd0, 3'd0}, // R8 R9 sel1
        '{1'b1, 1'b1, 1'b1, 2'd3, 32'd9,   1'b0, 32'd0,          32'd102, 32'd5, 32'd8, 32'd9, 3'd0}  // R6 R8 sel3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic rt, input logic we, input logic [1:0] sel,
                         input logic [31:0] wd, input logic iwe, input logic [31:0] id);
        step_i = st; retire_i = rt; wr_en_i = we; wr_sel_i = sel; wr_data_i = wd;
        inh_we_i = iwe; inh_data_i = id;
        @(negedge clk);
        step_i = 0; retire_i = 0; wr_en_i = 0; inh_we_i = 0;
    endtask

    task automatic check_all(input string req, input logic [31:0] cl, input logic [31:0] ch,
                             input logic [31:0] rl, input logic [31:0] rh, input logic [2:0] ih);
        chk({req, " cyc_lo"}, cyc_lo_o, cl);
        chk({req, " cyc_hi"}, cyc_hi_o, ch);
        chk({req, " ret_lo"}, ret_lo_o, rl);
        chk({req, " ret_hi"}, ret_hi_o, rh);
        chk({req, " inh"}, {29'd0, inh_o}, {29'd0, ih});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1", 0, 0, 0, 0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 3'd0);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].step, VECS[v].ret, VECS[v].we, VECS[v].sel, VECS[v].wd,
                  VECS[v].iwe, VECS[v].id);
            chk($sformatf("R2/R6 vec %0d cyc_lo", v), cyc_lo_o, VECS[v].e_cl);
            chk($sformatf("R6/R8 vec %0d cyc_hi", v), cyc_hi_o, VECS[v].e_ch);
            chk($sformatf("R3/R4 vec %0d ret_lo", v), ret_lo_o, VECS[v].e_rl);
            chk($sformatf("R6/R8 vec %0d ret_hi", v), ret_hi_o, VECS[v].e_rh);
            chk($sformatf("R7 vec %0d inh", v), {29'd0, inh_o}, {29'd0, VECS[v].e_inh});
        end

        // R5 carry: cycle low at all ones, high zero, written while idle (R9)
        drive(0, 0, 1, 2'd0, 32'hFFFF_FFFF, 0, 0);
        drive(0, 0, 1, 2'd1, 32'd0, 0, 0);
        drive(1, 0, 0, 2'd0, 0, 0, 0);
        chk("R5 cyc_lo wrap", cyc_lo_o, 32'd0);
        chk("R5 cyc_hi carry", cyc_hi_o, 32'd1);

        // R6 write low word while carry feeds high word (retire counter)
        drive(0, 0, 1, 2'd2, 32'hFFFF_FFFF, 0, 0);
        drive(0, 0, 1, 2'd3, 32'd3, 0, 0);
        drive(1, 1, 1, 2'd2, 32'h10, 0, 0);
        chk("R6 ret_lo written", ret_lo_o, 32'h10);
        chk("R6 ret_hi carried", ret_hi_o, 32'd4);

        // R6 write high word while low word wraps (cycle counter)
        drive(0, 0, 1, 2'd0, 32'hFFFF_FFFF, 0, 0);
        drive(1, 0, 1, 2'd1, 32'h20, 0, 0);
        chk("R6 cyc_lo wrapped", cyc_lo_o, 32'd0);
        chk("R6 cyc_hi written", cyc_hi_o, 32'h20);

        // R3 strobe without step leaves retire counter unchanged
        drive(0, 1, 0, 2'd0, 0, 0, 0);
        chk("R3 ret_lo no step", ret_lo_o, 32'h10);

        // R1 reset in mid-run
        drive(0, 0, 0, 2'd0, 0, 1, 32'h5);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid-run", 0, 0, 0, 0, 3'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule